// File: doc/BRIEF.md
# Multi-channel frame skew monitor

This block watches the frame-start pulses of a group of byte-wide channels that should arrive aligned. It works in one byte-clock domain. It measures, in byte clocks, how far the latest frame start trails the earliest one, counting only the channels whose enable bit is set. The measurement runs on every frame without any software trigger. When the spread goes beyond a fixed limit, which is 18 byte clocks by default, a sticky alarm is set.

A measurement window opens on the first enabled frame start. It closes in one of two ways:
- Every enabled channel has reported. The spread at that point is the result.
- The elapsed count reaches the limit while some enabled channel is still missing. The result is then the limit plus one, and the alarm is set.

Each result is registered into `skew` and announced by a one-cycle `skew_valid` strobe. This result stream has no ready signal and cannot be held back, so a consumer must capture it in the strobe cycle. The enable mask, the alarm and its clear stay plain level pins.

Top module: `frame_skew_monitor`

## Requirements
- R1: After reset, `alarm`, `skew_valid` and `skew` are all 0.
- R2: A window opens on the first enabled frame start. Once every enabled channel has reported, `skew` equals the number of clocks from the earliest to the latest enabled frame start. `skew` and a one-cycle `skew_valid` appear on the clock edge that ends the cycle of the last arrival.
- R3: When all enabled channels start in the same cycle, or only one channel is enabled, the result is 0 and the alarm is not set.
- R4: A frame start on a channel whose enable bit is 0 neither opens a window nor changes any result.
- R5: A spread equal to the limit (18) is reported as 18 and does not set the alarm.
- R6: When an enabled channel has not started by elapsed count 18, the window closes in that cycle. The result is reported as 19 and the alarm is set on the same edge.
- R7: Once set, the alarm stays set through later windows that stay within the limit, until it is cleared.
- R8: A one-cycle `alarm_clr` clears the alarm on the next edge. If a violation closes a window in the same cycle as the clear, the alarm stays set.
- R9: With no channel enabled, no result is reported and the alarm never sets.
- R10: Windows follow one another without software action, and each one produces its own result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chan_en | input | 8 | Per-channel enable mask; bit i includes channel i |
| frame_start | input | 8 | Per-channel one-cycle frame-start pulse |
| alarm_clr | input | 1 | One-cycle clear of the sticky alarm |
| alarm | output | 1 | Sticky over-limit alarm |
| skew | output | 8 | Last measured spread in clocks, saturated at 255 |
| skew_valid | output | 1 | One-cycle strobe marking a new `skew` value |

## Verification
The assertions make three assumptions about the inputs:
- `frame_start` pulses once per channel per window.
- `chan_en` holds steady while a window is open.
- `alarm_clr` lasts one cycle.

The bench drives each window from an offset table, with every offset inside the limit or absent. It keeps the enable mask fixed across each window, and it leaves more than 18 idle cycles between windows so that no late pulse can open a stray window. Under these conditions the strobe can only follow a cycle in which some channel was enabled, and the alarm can only drop after a clear with no violation.

// File: rtl/skewmon_pkg.sv
package skewmon_pkg;
  localparam int unsigned SKEW_W = 8;

  function automatic logic [SKEW_W-1:0] sat_skew(input logic [31:0] v);
    if (v > 32'((1 << SKEW_W) - 1)) return '1;
    return v[SKEW_W-1:0];
  endfunction
endpackage

// File: rtl/skewmon_arrivals.sv
module skewmon_arrivals #(
  parameter int unsigned NCH = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_en,
  input  logic [NCH-1:0] frame_start,
  input  logic           flush,
  output logic [NCH-1:0] hits,
  output logic           any_hit,
  output logic           all_in
);
  logic [NCH-1:0] seen_nx;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic seen_q;
    assign hits[g]    = frame_start[g] & chan_en[g];
    assign seen_nx[g] = seen_q | hits[g];
    always_ff @(posedge clk) begin
      if (!rst_n || flush) seen_q <= 1'b0;
      else                 seen_q <= seen_nx[g];
    end
  end

  assign any_hit = |hits;
  // complete when every enabled lane has now been seen
  assign all_in  = (chan_en != '0) && ((seen_nx & chan_en) == chan_en);
endmodule

// File: rtl/skewmon_timer.sv
module skewmon_timer #(
  parameter int unsigned LIMIT = 18,
  parameter int unsigned MW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  output logic          active,
  output logic [MW-1:0] elapsed,
  output logic          timed_out
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      elapsed <= '0;
    end else if (start) begin
      active  <= 1'b1;
      elapsed <= MW'(1);
    end else if (stop) begin
      active  <= 1'b0;
      elapsed <= '0;
    end else if (active) begin
      elapsed <= elapsed + MW'(1);
    end
  end

  assign timed_out = active && (elapsed >= MW'(LIMIT));
endmodule

// File: rtl/skewmon_report.sv
module skewmon_report
  import skewmon_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              close,
  input  logic [SKEW_W-1:0] measured,
  input  logic              violation,
  input  logic              alarm_clr,
  output logic              alarm,
  output logic [SKEW_W-1:0] skew,
  output logic              skew_valid
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alarm      <= 1'b0;
      skew       <= '0;
      skew_valid <= 1'b0;
    end else begin
      skew_valid <= close;
      if (close) skew <= measured;
      // a new violation wins over a simultaneous clear
      alarm <= (alarm & ~alarm_clr) | (close & violation);
    end
  end
endmodule

// File: rtl/frame_skew_monitor.sv
module frame_skew_monitor
  import skewmon_pkg::*;
#(
  parameter int unsigned NCH   = 8,
  parameter int unsigned LIMIT = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH-1:0]    chan_en,
  input  logic [NCH-1:0]    frame_start,
  input  logic              alarm_clr,
  output logic              alarm,
  output logic [SKEW_W-1:0] skew,
  output logic              skew_valid
);
  localparam int unsigned MW = $clog2(LIMIT + 2);

  logic [NCH-1:0] hits;
  logic           any_hit, all_in;
  logic           active, timed_out;
  logic [MW-1:0]  elapsed;
  logic           open_now, close_now, abort_now;
  logic [MW-1:0]  measured;
  logic           violation;

  assign open_now  = !active && any_hit;
  assign abort_now = active && (chan_en == '0);

  always_comb begin
    close_now = 1'b0;
    measured  = '0;
    if (open_now && all_in) begin
      close_now = 1'b1;
    end else if (active && all_in) begin
      close_now = 1'b1;
      measured  = elapsed;
    end else if (timed_out && !abort_now) begin
      close_now = 1'b1;
      measured  = MW'(LIMIT + 1);
    end
  end

  assign violation = measured > MW'(LIMIT);

  skewmon_arrivals #(.NCH(NCH)) u_arr (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .frame_start(frame_start),
    .flush(close_now | abort_now), .hits(hits), .any_hit(any_hit), .all_in(all_in)
  );

  skewmon_timer #(.LIMIT(LIMIT), .MW(MW)) u_tmr (
    .clk(clk), .rst_n(rst_n), .start(open_now & ~all_in),
    .stop(close_now | abort_now), .active(active), .elapsed(elapsed),
    .timed_out(timed_out)
  );

  skewmon_report u_rep (
    .clk(clk), .rst_n(rst_n), .close(close_now),
    .measured(sat_skew(32'(measured))), .violation(violation),
    .alarm_clr(alarm_clr), .alarm(alarm), .skew(skew), .skew_valid(skew_valid)
  );
endmodule

// File: rtl/skewmon_checker.sv
module skewmon_checker #(
  parameter int unsigned NCH   = 8,
  parameter int unsigned LIMIT = 18
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] chan_en,
  input logic           alarm_clr,
  input logic           alarm,
  input logic [7:0]     skew,
  input logic           skew_valid
);
  // R2 R6: a result never exceeds the timeout value
  p_skew_bounded_r6: assert property (@(posedge clk) disable iff (!rst_n)
    skew_valid |-> (32'(skew) <= LIMIT + 1));

  // R6: an over-limit result comes with the alarm set
  p_over_limit_alarms_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (skew_valid && 32'(skew) > LIMIT) |-> alarm);

  // R7: without a clear the alarm holds
  p_alarm_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (alarm && !alarm_clr) |=> alarm);

  // R8: after a clear the alarm is low unless a violation just closed
  p_clear_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    alarm_clr |=> (!alarm || (skew_valid && 32'(skew) > LIMIT)));

  // R9: no result can follow a cycle with nothing enabled
  p_no_lanes_no_result_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(chan_en) == '0) |-> !skew_valid);

  // R7 R8: the alarm only rises with an over-limit report
  p_alarm_rise_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> (skew_valid && 32'(skew) > LIMIT));
endmodule

bind frame_skew_monitor skewmon_checker #(.NCH(NCH), .LIMIT(LIMIT)) u_chk (
  .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .alarm_clr(alarm_clr),
  .alarm(alarm), .skew(skew), .skew_valid(skew_valid)
);

// File: tb/tb_frame_skew_monitor.sv
module tb_frame_skew_monitor;
  localparam int NCH = 8;
  localparam int LIMIT = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NCH-1:0] chan_en = '0;
  logic [NCH-1:0] frame_start = '0;
  logic alarm_clr = 1'b0;
  logic alarm, skew_valid;
  logic [7:0] skew;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  int exp_q[$];
  string tag_q[$];

  always #2.5 clk = ~clk;  // 200 MHz

  frame_skew_monitor #(.NCH(NCH), .LIMIT(LIMIT)) dut (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .frame_start(frame_start),
    .alarm_clr(alarm_clr), .alarm(alarm), .skew(skew), .skew_valid(skew_valid)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: every strobe pops one expected result
  always @(negedge clk) begin
    if (rst_n && skew_valid) begin
      if (exp_q.size() == 0) begin
        check("R4/R9 unexpected result", 1, 0);
      end else begin
        automatic int e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, int'(skew), e);
      end
    end
  end

  // driver: offs[i] < 0 means channel i sends no start
  task automatic run_window(input string req, input logic [NCH-1:0] en,
                            input int offs[NCH], input int clr_at);
    int mn = 1 << 20, mx = -1, last = clr_at;
    bit missing = 0;
    for (int i = 0; i < NCH; i++) begin
      if (offs[i] > last) last = offs[i];
      if (en[i]) begin
        if (offs[i] < 0) missing = 1;
        else begin
          if (offs[i] < mn) mn = offs[i];
          if (offs[i] > mx) mx = offs[i];
        end
      end
    end
    if (mx >= 0) begin
      exp_q.push_back(missing ? LIMIT + 1 : mx - mn);
      tag_q.push_back(req);
    end
    @(negedge clk);
    chan_en = en;
    for (int c = 0; c <= last; c++) begin
      for (int i = 0; i < NCH; i++) frame_start[i] = (offs[i] == c);
      alarm_clr = (c == clr_at);
      @(negedge clk);
    end
    frame_start = '0;
    alarm_clr = 1'b0;
    repeat (LIMIT + 4) @(negedge clk);
  endtask

  task automatic pulse_clear();
    alarm_clr = 1'b1;
    @(negedge clk);
    alarm_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int o[NCH];
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 alarm", alarm, 0);
    check("R1 valid", skew_valid, 0);
    check("R1 skew", skew, 0);

    o = '{0, 3, 1, 5, 2, 7, 4, 6};
    run_window("R2 spread 7", 8'hFF, o, -1);
    o = '{4, 4, 4, 4, 4, 4, 4, 4};
    run_window("R3 aligned", 8'hFF, o, -1);
    o = '{-1, -1, 2, -1, -1, -1, -1, -1};
    run_window("R3 single lane", 8'h04, o, -1);
    // R4: disabled lanes start early and late, must not count
    o = '{0, 5, 5, 9, 30, 5, 5, 5};
    run_window("R4 masked lanes", 8'h06, o, -1);
    check("R3 R4 alarm low", alarm, 0);
    o = '{1, 19, 5, -1, -1, -1, -1, -1};
    run_window("R5 spread at limit", 8'h07, o, -1);
    check("R5 alarm low", alarm, 0);
    o = '{0, 3, -1, -1, -1, -1, -1, -1};
    run_window("R6 timeout", 8'h0F, o, -1);
    check("R6 alarm set", alarm, 1);
    o = '{2, 0, 1, 3, 0, 0, 0, 0};
    run_window("R7 in-limit window", 8'h0F, o, -1);
    check("R7 alarm held", alarm, 1);
    pulse_clear();
    check("R8 cleared", alarm, 0);
    o = '{0, -1, -1, -1, -1, -1, -1, -1};
    run_window("R8 timeout with clear", 8'h03, o, LIMIT);
    check("R8 clear loses to violation", alarm, 1);
    pulse_clear();
    check("R8 cleared again", alarm, 0);
    o = '{0, 1, 2, 3, 4, 5, 6, 7};
    run_window("R9 nothing enabled", 8'h00, o, -1);
    check("R9 alarm low", alarm, 0);
    // R10: back-to-back windows, no software action
    for (int k = 0; k < 4; k++) begin
      for (int i = 0; i < NCH; i++) o[i] = (i * (k + 3)) % (4 + 3 * k);
      run_window("R10 repeated window", 8'hFF, o, -1);
    end
    check("R10 all results seen", exp_q.size(), 0);
    check("R10 alarm low", alarm, 0);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule